// File: doc/BRIEF.md
# Host Command Decoder with Status Readback

This block takes commands that a host interface captures in its own clock domain and carries each one into the processing clock domain. Each command is an 8-bit opcode with a 16-bit value. There the block decodes the pair and updates a bank of runtime settings: operating mode, a chirp trigger, the detection threshold, a per-stream output enable mask and six chirp timing values. The threshold is driven out as a live register, so downstream comparison logic always works from the current runtime value and never from a fixed constant. The stream enable mask is also sent to a third, write-side clock domain, where it gates individual output streams.

A command crosses domains through a toggle handshake. The source domain flips a toggle and holds the opcode and value. The processing domain synchronises the toggle and catches the edge, which yields exactly one decode per command. The host must leave at least CMD_SYNC + 3 processing-clock cycles between commands, so the held data is stable when it is captured. Each bit of the stream mask reaches the write-side domain through its own two-stage flip-flop synchroniser.

A status opcode makes the block send a seven-word packet over a valid/ready word port. The packet is a snapshot of every setting, taken when the packet starts. If requests arrive while a packet is being sent, they are remembered as one pending request, which is served right after the current packet ends.

Top module: `host_cmd_decoder`

## Requirements
- R1: Opcode 0x01 loads the mode from the low 2 value bits into `cfg_mode`. Opcode 0x03 loads all 16 value bits into `det_threshold`. Both changes are visible a few processing cycles after the command.
- R2: While `proc_rst` is high and after it falls, the settings hold their defaults: mode 0, threshold 0x0400, every stream enabled, and timing values 1000, 4000, 500, 50, 2000 and 32 for opcodes 0x10 to 0x15. `wr_stream_en` resets to all ones, and `stat_valid` and `chirp_trigger` reset to 0.
- R3: An opcode outside {0x01, 0x02, 0x03, 0x04, 0x10–0x15, 0xFF} changes no setting, fires no trigger and starts no packet.
- R4: Each opcode 0x02 command produces exactly one `chirp_trigger` pulse of one processing cycle, whatever its value.
- R5: Opcode 0x04 loads `stream_en` from value bits [STREAMS-1:0]. Bit i enables stream i.
- R6: `wr_stream_en` follows `stream_en` after passing through a per-bit flip-flop synchroniser in the `wr_clk` domain.
- R7: Opcodes 0x10, 0x11, 0x12, 0x13, 0x14 and 0x15 load, in that order, long chirp length, long listen length, guard length, short chirp length, short listen length and chirps per elevation step.
- R8: Opcode 0xFF yields exactly one packet of 7 words, with `stat_last` high on the seventh word only. Word 0 is {0xA5 in [31:24], mode in [23:22], the stream mask zero-extended to 6 bits in [21:16], chirps per elevation in [15:0]}. Word 1 is the threshold. Words 2–6 are the values of opcodes 0x10–0x14. Each of words 1–6 carries its 16-bit value in bits [15:0] with zeros above.
- R9: While `stat_valid` is high and `stat_ready` is low, `stat_data` and `stat_last` stay unchanged.
- R10: One or more status requests received during a packet produce exactly one further packet, which starts after the current one ends.
- R11: A packet reports the settings as they stood when it started, even if commands change them while the packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Host-side capture clock |
| src_rst | input | 1 | Synchronous active-high reset, src_clk domain |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_opcode | input | 8 | Command opcode |
| cmd_value | input | 16 | Command value |
| proc_clk | input | 1 | Processing clock (100 MHz target) |
| proc_rst | input | 1 | Synchronous active-high reset, proc_clk domain |
| cfg_mode | output | 2 | Operating mode |
| chirp_trigger | output | 1 | Single-cycle chirp trigger pulse |
| det_threshold | output | 16 | Detection threshold |
| stream_en | output | STREAMS | Stream enable mask, proc_clk domain |
| long_chirp_len | output | 16 | Long chirp length |
| long_listen_len | output | 16 | Long listen length |
| guard_len | output | 16 | Guard length |
| short_chirp_len | output | 16 | Short chirp length |
| short_listen_len | output | 16 | Short listen length |
| chirps_per_elev | output | 16 | Chirps per elevation step |
| stat_valid | output | 1 | Status word valid |
| stat_ready | input | 1 | Status word accepted by consumer |
| stat_data | output | 32 | Status word |
| stat_last | output | 1 | Marks the seventh status word |
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, wr_clk domain |
| wr_stream_en | output | STREAMS | Stream enable mask, wr_clk domain |

## Verification
The bench builds the block with STREAMS = 4, CMD_SYNC = 3 and STREAM_SYNC = 2, and runs three unrelated clock periods. Four streams make the zero padding of the mask field in the header word visible, and a value with ones above bit 3 shows that the upper value bits are dropped. A three-stage command synchroniser lengthens the crossing, which widens the window in which commands and requests can land while a stalled packet is held. That lets the snapshot and pending-request behaviour be reached in a single stall.

// File: rtl/hcd_pkg.sv
`timescale 1ns/1ps
package hcd_pkg;

    localparam int OP_W        = 8;
    localparam int VAL_W       = 16;
    localparam int MODE_W      = 2;
    localparam int MASK_MAX    = 6;
    localparam int N_TIMING    = 6;
    localparam int STAT_W      = 32;
    localparam int STAT_WORDS  = 7;
    localparam int STAT_IDX_W  = $clog2(STAT_WORDS);
    localparam logic [7:0] STAT_MARK = 8'hA5;

    localparam logic [OP_W-1:0] OPC_MODE    = 8'h01;
    localparam logic [OP_W-1:0] OPC_TRIG    = 8'h02;
    localparam logic [OP_W-1:0] OPC_THRESH  = 8'h03;
    localparam logic [OP_W-1:0] OPC_STREAM  = 8'h04;
    localparam logic [OP_W-1:0] OPC_TIMBASE = 8'h10;
    localparam logic [OP_W-1:0] OPC_STATUS  = 8'hFF;

    // timing register slots, in opcode order from OPC_TIMBASE
    localparam int TIM_LCHIRP  = 0;
    localparam int TIM_LLISTEN = 1;
    localparam int TIM_GUARD   = 2;
    localparam int TIM_SCHIRP  = 3;
    localparam int TIM_SLISTEN = 4;
    localparam int TIM_CPE     = 5;

    localparam logic [VAL_W-1:0] DEF_THRESH = 16'h0400;
    localparam logic [N_TIMING-1:0][VAL_W-1:0] DEF_TIMING = {
        16'd32, 16'd2000, 16'd50, 16'd500, 16'd4000, 16'd1000
    };

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [VAL_W-1:0] val;
    } cmd_t;

    typedef struct packed {
        logic [MODE_W-1:0]                 mode;
        logic [VAL_W-1:0]                  thresh;
        logic [MASK_MAX-1:0]               mask;
        logic [N_TIMING-1:0][VAL_W-1:0]    timing;
    } cfg_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    function automatic logic is_timing_op(input logic [OP_W-1:0] op);
        return (op >= OPC_TIMBASE) && (op < OPC_TIMBASE + OP_W'(N_TIMING));
    endfunction

    function automatic logic is_known_op(input logic [OP_W-1:0] op);
        return (op == OPC_MODE) || (op == OPC_TRIG) || (op == OPC_THRESH) ||
               (op == OPC_STREAM) || (op == OPC_STATUS) || is_timing_op(op);
    endfunction

    // word layout: header, threshold, then timing slots 0..4
    function automatic logic [STAT_W-1:0] status_word(input cfg_t c,
                                                      input logic [STAT_IDX_W-1:0] idx);
        logic [STAT_W-1:0] w;
        logic [STAT_IDX_W-1:0] slot;
        slot = idx - STAT_IDX_W'(2);
        case (idx)
            STAT_IDX_W'(0): w = {STAT_MARK, c.mode, c.mask, c.timing[TIM_CPE]};
            STAT_IDX_W'(1): w = {16'h0000, c.thresh};
            default:        w = {16'h0000, c.timing[slot]};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hcd_sync_chain.sv
`timescale 1ns/1ps
module hcd_sync_chain #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff <= {STAGES{RST_VAL}};
        end else begin
            ff <= {ff[STAGES-2:0], d};
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/hcd_toggle_xfer.sv
`timescale 1ns/1ps
module hcd_toggle_xfer #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_valid,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);
    logic         src_tog;
    logic [W-1:0] src_hold;
    logic         tog_sync;
    logic         tog_seen;
    logic         tog_edge;

    // source side: flip the toggle and park the payload
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            src_tog  <= 1'b0;
            src_hold <= '0;
        end else if (src_valid) begin
            src_tog  <= ~src_tog;
            src_hold <= src_data;
        end
    end

    hcd_sync_chain #(
        .STAGES  (STAGES),
        .RST_VAL (1'b0)
    ) u_tog_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (src_tog),
        .q   (tog_sync)
    );

    assign tog_edge = tog_sync ^ tog_seen;

    // destination side: one pulse per toggle edge, payload captured with it
    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            tog_seen  <= 1'b0;
            dst_pulse <= 1'b0;
            dst_data  <= '0;
        end else begin
            tog_seen  <= tog_sync;
            dst_pulse <= tog_edge;
            if (tog_edge) begin
                dst_data <= src_hold;
            end
        end
    end
endmodule

// File: rtl/hcd_regbank.sv
`timescale 1ns/1ps
module hcd_regbank
    import hcd_pkg::*;
#(
    parameter int STREAMS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_pulse,
    input  logic [OP_W-1:0]    op,
    input  logic [VAL_W-1:0]   val,
    output cfg_t               cfg,
    output logic [STREAMS-1:0] stream_mask,
    output logic               trig_pulse,
    output logic               stat_req
);
    logic [MODE_W-1:0]  mode_q;
    logic [VAL_W-1:0]   thr_q;
    logic [STREAMS-1:0] mask_q;
    logic [VAL_W-1:0]   tim_q [N_TIMING];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            thr_q      <= DEF_THRESH;
            mask_q     <= '1;
            trig_pulse <= 1'b0;
            stat_req   <= 1'b0;
        end else begin
            trig_pulse <= cmd_pulse && (op == OPC_TRIG);
            stat_req   <= cmd_pulse && (op == OPC_STATUS);
            if (cmd_pulse) begin
                case (op)
                    OPC_MODE:   mode_q <= val[MODE_W-1:0];
                    OPC_THRESH: thr_q  <= val;
                    OPC_STREAM: mask_q <= val[STREAMS-1:0];
                    default:    ;
                endcase
            end
        end
    end

    // one register per timing opcode
    for (genvar g = 0; g < N_TIMING; g++) begin : g_tim
        localparam logic [OP_W-1:0] SLOT_OP = OPC_TIMBASE + OP_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                tim_q[g] <= DEF_TIMING[g];
            end else if (cmd_pulse && (op == SLOT_OP)) begin
                tim_q[g] <= val;
            end
        end
    end

    always_comb begin
        cfg = '0;
        cfg.mode   = mode_q;
        cfg.thresh = thr_q;
        cfg.mask[STREAMS-1:0] = mask_q;
        for (int i = 0; i < N_TIMING; i++) begin
            cfg.timing[i] = tim_q[i];
        end
    end

    assign stream_mask = mask_q;
endmodule

// File: rtl/hcd_status_tx.sv
`timescale 1ns/1ps
module hcd_status_tx
    import hcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  cfg_t              cfg,
    input  logic              ready,
    output logic              valid,
    output logic [STAT_W-1:0] data,
    output logic              last
);
    localparam logic [STAT_IDX_W-1:0] LAST_IDX = STAT_IDX_W'(STAT_WORDS - 1);

    tx_state_e             st;
    logic [STAT_IDX_W-1:0] idx;
    logic                  pend;
    cfg_t                  snap;
    logic                  accept;
    logic                  fin;
    logic                  start;

    assign accept = (st == TX_SEND) && ready;
    assign fin    = accept && (idx == LAST_IDX);
    assign start  = ((st == TX_IDLE) || fin) && (req || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            idx  <= '0;
            pend <= 1'b0;
            snap <= '0;
        end else begin
            if (start) begin
                st   <= TX_SEND;
                idx  <= '0;
                snap <= cfg;
            end else if (fin) begin
                st   <= TX_IDLE;
            end else if (accept) begin
                idx  <= idx + STAT_IDX_W'(1);
            end

            if (start) begin
                pend <= 1'b0;
            end else if (req) begin
                pend <= 1'b1;
            end
        end
    end

    assign valid = (st == TX_SEND);
    assign data  = status_word(snap, idx);
    assign last  = valid && (idx == LAST_IDX);
endmodule

// File: rtl/host_cmd_decoder.sv
`timescale 1ns/1ps
module host_cmd_decoder
    import hcd_pkg::*;
#(
    parameter int STREAMS     = 3,
    parameter int CMD_SYNC    = 2,
    parameter int STREAM_SYNC = 2
) (
    input  logic               src_clk,
    input  logic               src_rst,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_opcode,
    input  logic [15:0]        cmd_value,
    input  logic               proc_clk,
    input  logic               proc_rst,
    output logic [1:0]         cfg_mode,
    output logic               chirp_trigger,
    output logic [15:0]        det_threshold,
    output logic [STREAMS-1:0] stream_en,
    output logic [15:0]        long_chirp_len,
    output logic [15:0]        long_listen_len,
    output logic [15:0]        guard_len,
    output logic [15:0]        short_chirp_len,
    output logic [15:0]        short_listen_len,
    output logic [15:0]        chirps_per_elev,
    output logic               stat_valid,
    input  logic               stat_ready,
    output logic [31:0]        stat_data,
    output logic               stat_last,
    input  logic               wr_clk,
    input  logic               wr_rst,
    output logic [STREAMS-1:0] wr_stream_en
);
    localparam int CMD_W = $bits(cmd_t);

    cmd_t             cmd_in;
    cmd_t             cmd_rx;
    logic             cmd_pulse;
    logic [OP_W-1:0]  rx_op;
    logic [VAL_W-1:0] rx_val;
    cfg_t             cfg;
    logic             stat_req;

    assign cmd_in = {cmd_opcode, cmd_value};

    hcd_toggle_xfer #(
        .W      (CMD_W),
        .STAGES (CMD_SYNC)
    ) u_cmd_xfer (
        .src_clk   (src_clk),
        .src_rst   (src_rst),
        .src_valid (cmd_valid),
        .src_data  (cmd_in),
        .dst_clk   (proc_clk),
        .dst_rst   (proc_rst),
        .dst_pulse (cmd_pulse),
        .dst_data  (cmd_rx)
    );

    assign rx_op  = cmd_rx.op;
    assign rx_val = cmd_rx.val;

    hcd_regbank #(
        .STREAMS (STREAMS)
    ) u_regs (
        .clk         (proc_clk),
        .rst         (proc_rst),
        .cmd_pulse   (cmd_pulse),
        .op          (rx_op),
        .val         (rx_val),
        .cfg         (cfg),
        .stream_mask (stream_en),
        .trig_pulse  (chirp_trigger),
        .stat_req    (stat_req)
    );

    hcd_status_tx u_stat (
        .clk   (proc_clk),
        .rst   (proc_rst),
        .req   (stat_req),
        .cfg   (cfg),
        .ready (stat_ready),
        .valid (stat_valid),
        .data  (stat_data),
        .last  (stat_last)
    );

    assign cfg_mode         = cfg.mode;
    assign det_threshold    = cfg.thresh;
    assign long_chirp_len   = cfg.timing[TIM_LCHIRP];
    assign long_listen_len  = cfg.timing[TIM_LLISTEN];
    assign guard_len        = cfg.timing[TIM_GUARD];
    assign short_chirp_len  = cfg.timing[TIM_SCHIRP];
    assign short_listen_len = cfg.timing[TIM_SLISTEN];
    assign chirps_per_elev  = cfg.timing[TIM_CPE];

    // each mask bit gets its own synchroniser into the write-side domain
    for (genvar b = 0; b < STREAMS; b++) begin : g_wr_sync
        hcd_sync_chain #(
            .STAGES  (STREAM_SYNC),
            .RST_VAL (1'b1)
        ) u_bit (
            .clk (wr_clk),
            .rst (wr_rst),
            .d   (stream_en[b]),
            .q   (wr_stream_en[b])
        );
    end
endmodule

// File: rtl/hcd_checker.sv
`timescale 1ns/1ps
module hcd_checker
    import hcd_pkg::*;
#(
    parameter int STREAMS = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_pulse,
    input logic [OP_W-1:0]    cmd_op,
    input logic [1:0]         cfg_mode,
    input logic [15:0]        det_threshold,
    input logic [STREAMS-1:0] stream_en,
    input logic               chirp_trigger,
    input logic               stat_valid,
    input logic               stat_ready,
    input logic [31:0]        stat_data,
    input logic               stat_last
);
    logic [STAT_IDX_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (stat_valid && stat_ready) begin
            wcnt <= stat_last ? '0 : wcnt + STAT_IDX_W'(1);
        end
    end

    // R2: defaults after reset
    a_r2_reset_defaults: assert property (@(posedge clk)
        rst |=> (det_threshold == DEF_THRESH) && (cfg_mode == '0) &&
                (stream_en == '1) && !stat_valid && !chirp_trigger);

    // R3: unknown opcode leaves settings alone
    a_r3_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_pulse && !is_known_op(cmd_op)) |=>
            $stable(det_threshold) && $stable(cfg_mode) && $stable(stream_en) && !chirp_trigger);

    // R4: trigger is a single-cycle pulse
    a_r4_trig_single: assert property (@(posedge clk) disable iff (rst)
        chirp_trigger |=> !chirp_trigger);

    // R8: last flag lands on the seventh word, and only there
    a_r8_last_position: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_last == (wcnt == STAT_IDX_W'(STAT_WORDS - 1))));

    // R8: first word carries the header marker
    a_r8_header_mark: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && (wcnt == '0)) |-> (stat_data[31:24] == STAT_MARK));

    // R9: word held while stalled
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && !stat_ready) |=> stat_valid && $stable(stat_data) && $stable(stat_last));
endmodule

bind host_cmd_decoder hcd_checker #(
    .STREAMS (STREAMS)
) chk_i (
    .clk           (proc_clk),
    .rst           (proc_rst),
    .cmd_pulse     (cmd_pulse),
    .cmd_op        (rx_op),
    .cfg_mode      (cfg_mode),
    .det_threshold (det_threshold),
    .stream_en     (stream_en),
    .chirp_trigger (chirp_trigger),
    .stat_valid    (stat_valid),
    .stat_ready    (stat_ready),
    .stat_data     (stat_data),
    .stat_last     (stat_last)
);

// File: tb/host_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module host_cmd_decoder_tb_top;

    localparam int STREAMS = 4;
    localparam int NVEC    = 16;

    // {opcode, value}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h01_0002, 24'h03_1234, 24'h05_BEEF, 24'h04_0005,
        24'h10_0BB8, 24'h11_2222, 24'h12_0333, 24'h13_0044,
        24'h14_5555, 24'h15_0066, 24'h00_FFFF, 24'h16_7777,
        24'h04_00FA, 24'h01_0007, 24'hFE_0000, 24'h03_0000
    };

    logic src_clk = 1'b0, proc_clk = 1'b0, wr_clk = 1'b0;
    logic src_rst = 1'b1, proc_rst = 1'b1, wr_rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [15:0] cmd_value = '0;
    logic stat_ready = 1'b0;
    logic [1:0] cfg_mode;
    logic chirp_trigger, stat_valid, stat_last;
    logic [15:0] det_threshold, long_chirp_len, long_listen_len, guard_len;
    logic [15:0] short_chirp_len, short_listen_len, chirps_per_elev;
    logic [STREAMS-1:0] stream_en, wr_stream_en;
    logic [31:0] stat_data;

    always #4   proc_clk = ~proc_clk;
    always #6.5 src_clk  = ~src_clk;
    always #5.5 wr_clk   = ~wr_clk;

    host_cmd_decoder #(
        .STREAMS (STREAMS), .CMD_SYNC (3), .STREAM_SYNC (2)
    ) dut_i (
        .src_clk (src_clk), .src_rst (src_rst), .cmd_valid (cmd_valid),
        .cmd_opcode (cmd_opcode), .cmd_value (cmd_value),
        .proc_clk (proc_clk), .proc_rst (proc_rst),
        .cfg_mode (cfg_mode), .chirp_trigger (chirp_trigger),
        .det_threshold (det_threshold), .stream_en (stream_en),
        .long_chirp_len (long_chirp_len), .long_listen_len (long_listen_len),
        .guard_len (guard_len), .short_chirp_len (short_chirp_len),
        .short_listen_len (short_listen_len), .chirps_per_elev (chirps_per_elev),
        .stat_valid (stat_valid), .stat_ready (stat_ready),
        .stat_data (stat_data), .stat_last (stat_last),
        .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_stream_en (wr_stream_en)
    );

    int checks = 0;
    int fails  = 0;
    int trig_cnt = 0;
    int trig_wide = 0;
    logic trig_prev = 1'b0;

    // bench model of the settings, built from the requirements
    logic [1:0]         m_mode;
    logic [15:0]        m_thr;
    logic [STREAMS-1:0] m_mask;
    logic [15:0]        m_tim [6];

    logic [31:0] pw [7];
    logic        pl [7];
    logic [31:0] ew [7];
    bit held_bad, pkt_to;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_mode = 2'd0; m_thr = 16'h0400; m_mask = '1;
        m_tim[0] = 16'd1000; m_tim[1] = 16'd4000; m_tim[2] = 16'd500;
        m_tim[3] = 16'd50;   m_tim[4] = 16'd2000; m_tim[5] = 16'd32;
    endfunction

    function automatic void m_apply(input logic [7:0] op, input logic [15:0] v);
        if (op == 8'h01) m_mode = v[1:0];
        else if (op == 8'h03) m_thr = v;
        else if (op == 8'h04) m_mask = v[STREAMS-1:0];
        else if (op >= 8'h10 && op <= 8'h15) m_tim[op - 8'h10] = v;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        if (op == 8'h01 || op == 8'h03) return "R1";
        if (op == 8'h04) return "R5";
        if (op >= 8'h10 && op <= 8'h15) return "R7";
        return "R3";
    endfunction

    function automatic logic [127:0] dut_state();
        return {cfg_mode, det_threshold, stream_en, long_chirp_len, long_listen_len,
                guard_len, short_chirp_len, short_listen_len, chirps_per_elev};
    endfunction

    function automatic logic [127:0] model_state();
        return {m_mode, m_thr, m_mask, m_tim[0], m_tim[1], m_tim[2], m_tim[3], m_tim[4], m_tim[5]};
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        if (w == 0) return {8'hA5, m_mode, 2'b00, m_mask, m_tim[5]};
        if (w == 1) return {16'h0000, m_thr};
        return {16'h0000, m_tim[w-2]};
    endfunction

    always @(negedge proc_clk) begin
        if (proc_rst) begin
            trig_prev = 1'b0;
        end else begin
            if (chirp_trigger) trig_cnt++;
            if (chirp_trigger && trig_prev) trig_wide++;
            trig_prev = chirp_trigger;
        end
    end

    task automatic send_cmd(input logic [7:0] op, input logic [15:0] v);
        @(posedge src_clk); #1;
        cmd_valid = 1'b1; cmd_opcode = op; cmd_value = v;
        @(posedge src_clk); #1;
        cmd_valid = 1'b0;
        repeat (18) @(negedge proc_clk);
    endtask

    task automatic read_pkt(input int stall);
        held_bad = 1'b0; pkt_to = 1'b0;
        for (int w = 0; w < 7; w++) begin
            int n;
            n = 0;
            stat_ready = 1'b0;
            while (!stat_valid && n < 400) begin
                @(negedge proc_clk);
                n++;
            end
            if (!stat_valid) begin
                pkt_to = 1'b1;
                return;
            end
            pw[w] = stat_data; pl[w] = stat_last;
            for (int s = 0; s < stall; s++) begin
                @(negedge proc_clk);
                if (!stat_valid || stat_data != pw[w] || stat_last != pl[w]) held_bad = 1'b1;
            end
            stat_ready = 1'b1;
            @(negedge proc_clk);
            stat_ready = 1'b0;
        end
    endtask

    task automatic check_pkt(input string req);
        chk(!pkt_to, req, {127'd0, pkt_to}, 128'd0);
        for (int w = 0; w < 7; w++) begin
            chk(pw[w] == ew[w] && pl[w] == (w == 6), req,
                {95'd0, pl[w], pw[w]}, {95'd0, (w == 6), ew[w]});
        end
    endtask

    task automatic fill_expected();
        for (int w = 0; w < 7; w++) ew[w] = exp_word(w);
    endtask

    task automatic do_reset();
        proc_rst = 1'b1; src_rst = 1'b1; wr_rst = 1'b1;
        repeat (8) @(negedge proc_clk);
        proc_rst = 1'b0; src_rst = 1'b0; wr_rst = 1'b0;
        repeat (6) @(negedge proc_clk);
        m_reset();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge proc_clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        m_reset();
        // reset values
        repeat (4) @(negedge proc_clk);
        chk(det_threshold == 16'h0400 && stream_en == '1, "R2 during reset",
            {det_threshold, stream_en}, {16'h0400, 4'hF});
        do_reset();
        chk(dut_state() == model_state(), "R2 defaults", dut_state(), model_state());
        chk(wr_stream_en == 4'hF && !stat_valid && !chirp_trigger, "R2 write side/status",
            {wr_stream_en, stat_valid, chirp_trigger}, {4'hF, 2'b00});

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  op;
            logic [15:0] v;
            op = VEC[i][23:16];
            v  = VEC[i][15:0];
            send_cmd(op, v);
            m_apply(op, v);
            chk(dut_state() == model_state(), tag_of(op), dut_state(), model_state());
            if (op == 8'h04) begin
                chk(wr_stream_en == m_mask, "R6 write-side mask", wr_stream_en, m_mask);
            end
        end
        chk(trig_cnt == 0, "R3 no trigger from other opcodes", trig_cnt, 0);
        chk(!stat_valid, "R3 no packet from other opcodes", stat_valid, 0);

        // R4 trigger pulses
        send_cmd(8'h02, 16'h0000);
        send_cmd(8'h02, 16'hFFFF);
        send_cmd(8'h02, 16'h1234);
        chk(trig_cnt == 3, "R4 one pulse per command", trig_cnt, 3);
        chk(trig_wide == 0, "R4 pulse width one cycle", trig_wide, 0);
        chk(dut_state() == model_state(), "R4 trigger leaves settings", dut_state(), model_state());

        // R8 plain packet
        fill_expected();
        send_cmd(8'hFF, 16'h0000);
        read_pkt(0);
        check_pkt("R8 packet");
        repeat (40) @(negedge proc_clk);
        chk(!stat_valid, "R8 exactly one packet", stat_valid, 0);

        // R9 stalled packet
        send_cmd(8'hFF, 16'h0000);
        read_pkt(3);
        check_pkt("R9 stalled packet");
        chk(!held_bad, "R9 word held while stalled", held_bad, 0);

        // R10 / R11: requests and a change while a packet is stalled
        fill_expected();
        send_cmd(8'hFF, 16'h0000);
        chk(stat_valid, "R11 packet started", stat_valid, 1);
        send_cmd(8'h03, 16'h0ABC);
        m_apply(8'h03, 16'h0ABC);
        send_cmd(8'hFF, 16'h0000);
        send_cmd(8'hFF, 16'h0000);
        read_pkt(0);
        check_pkt("R11 snapshot at start");
        fill_expected();
        read_pkt(0);
        check_pkt("R10 queued packet");
        repeat (60) @(negedge proc_clk);
        chk(!stat_valid, "R10 queued requests collapse", stat_valid, 0);

        // R2 reset in mid-run, then status reports defaults
        do_reset();
        chk(dut_state() == model_state(), "R2 defaults after second reset", dut_state(), model_state());
        chk(wr_stream_en == 4'hF, "R2 write side after second reset", wr_stream_en, 4'hF);
        fill_expected();
        send_cmd(8'hFF, 16'h0000);
        read_pkt(1);
        check_pkt("R8 packet of defaults");

        finish_run();
    end
endmodule